// File: doc/BRIEF.md
# Fractionally Adjustable Nanosecond Timer

A free-running time-of-day counter for a precision time protocol clock. On every clock cycle in which it runs, a 40-bit nanosecond count moves forward by a fixed step of 8 ns. A 32-bit sub-nanosecond accumulator collects a programmable fractional correction on each cycle. When that accumulator carries out, the step grows to 9 ns or shrinks to 7 ns, depending on the sign of the correction. The sign is held as a separate bit from the magnitude. This lets a servo tune the effective frequency in steps of 2^-32 ns per cycle. A correction of P parts per billion maps to a magnitude of P·2^26/1953125.

Software reaches the timer through a simple register port with combinational read data. Reading the sub-nanosecond residue freezes a snapshot of the nanosecond count, and later reads of the low and high words return that frozen copy. Writing is also atomic. A write to the low word stages a value, and a following write to the high word loads the full 40-bit count in one cycle and clears the accumulator. A control register holds a halt bit, which is set out of reset.

The staging logic is a two-state machine. `WS_IDLE` means nothing is staged. `WS_LO_HELD` means a low word is waiting. A low-word write moves the machine from `WS_IDLE` to `WS_LO_HELD`, and a further low-word write in `WS_LO_HELD` replaces the staged value. A high-word write in `WS_LO_HELD` commits the count and returns the machine to `WS_IDLE`. A high-word write in `WS_IDLE` is dropped and the machine stays in `WS_IDLE`.

Top module: `frac_ns_timer`

## Requirements
- R1: Register offsets on `addr`:
  - 0 is the residue, the 32-bit accumulator. It is read-only.
  - 1 is the low word, count bits 31:0.
  - 2 is the high word, count bits 39:32 in bits 7:0.
  - 3 is the rate word.
  - 4 is the control word, with the halt flag in bit 31.
  - Any other offset reads 0. `rdata` shows the selected register in the same cycle.
- R2: After reset, the following all read as zero: count, accumulator, snapshot and rate word. The control word reads 0x8000_0000, so the timer is halted, and the staging machine is in `WS_IDLE`.
- R3: While running with a rate magnitude of zero, the count grows by exactly 8 per clock.
- R4: With rate bit 31 clear, each clock adds magnitude bits 30:0 to the accumulator modulo 2^32. A carry out makes that clock's step 9 instead of 8.
- R5: With rate bit 31 set, the accumulator works the same way. A carry out makes that clock's step 7 instead of 8.
- R6: While control bit 31 is 1, the count and the accumulator hold their values. Writing the control word takes effect from the next clock. Only bit 31 is stored, and the other bits read 0.
- R7: A read of offset 0 copies the live count into the snapshot at that clock edge. Reads of offsets 1 and 2 return the snapshot, and the snapshot changes at no other time.
- R8: A write to offset 1 stages a value. A write to offset 2 while a value is staged loads {wdata[7:0], staged} into the count and clears the accumulator. This load replaces that clock's step, even while halted.
- R9: A write to offset 2 with no value staged is ignored. Writes to offset 0 are ignored.
- R10: The count wraps modulo 2^40.
- R11: Bits 31:8 of the high word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each edge is one timer tick |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe; a read of offset 0 takes the snapshot |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The bench loads the count near 2^40 and checks that it wraps to a small value. A design that carried into missing bits, or saturated, would read a wrong low word. It programs quarter-nanosecond rates of both signs and expects exactly 66 and 62 ns after eight ticks. A design that ignored the sign, or applied the carry with the wrong polarity, would miss those values. It issues a high-word write with nothing staged and a write to the residue, then reads back to show that nothing changed, and it checks that the snapshot stays frozen while the timer keeps running. Random traffic then compares every read against a model driven by the same strobes.

// File: rtl/frac_tmr_pkg.sv
package frac_tmr_pkg;

    localparam int unsigned REG_RESID = 0;
    localparam int unsigned REG_LOW   = 1;
    localparam int unsigned REG_HIGH  = 2;
    localparam int unsigned REG_RATE  = 3;
    localparam int unsigned REG_CTRL  = 4;

    typedef enum logic [0:0] {
        WS_IDLE    = 1'b0,
        WS_LO_HELD = 1'b1
    } wr_state_e;

endpackage

// File: rtl/frac_tmr_step.sv
module frac_tmr_step
    import frac_tmr_pkg::*;
#(
    parameter int NS_W    = 40,
    parameter int FRAC_W  = 32,
    parameter int DW      = 32,
    parameter int STEP_NS = 8
) (
    input  logic [NS_W-1:0]   ns_cur,
    input  logic [FRAC_W-1:0] frac_cur,
    input  logic [DW-1:0]     rate,
    output logic [NS_W-1:0]   ns_nxt,
    output logic [FRAC_W-1:0] frac_nxt
);
    localparam int MAG_W = DW - 1;

    logic [MAG_W-1:0]  mag;
    logic              slow;
    logic [FRAC_W-1:0] mag_ext;
    logic [FRAC_W:0]   sum;
    logic [NS_W-1:0]   step;

    assign mag  = rate[MAG_W-1:0];
    assign slow = rate[DW-1];

    generate
        if (FRAC_W > MAG_W) begin : g_widen
            assign mag_ext = {{(FRAC_W-MAG_W){1'b0}}, mag};
        end else begin : g_trim
            assign mag_ext = mag[MAG_W-1 -: FRAC_W];
        end
    endgenerate

    always_comb begin
        sum      = {1'b0, frac_cur} + {1'b0, mag_ext};
        frac_nxt = sum[FRAC_W-1:0];
        if (!sum[FRAC_W])
            step = NS_W'(STEP_NS);
        else if (slow)
            step = NS_W'(STEP_NS - 1);
        else
            step = NS_W'(STEP_NS + 1);
        ns_nxt = ns_cur + step;
    end

endmodule

// File: rtl/frac_tmr_wr_fsm.sv
module frac_tmr_wr_fsm
    import frac_tmr_pkg::*;
#(
    parameter int NS_W = 40,
    parameter int DW   = 32,
    parameter int AW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic            commit,
    output logic [NS_W-1:0] commit_ns
);
    localparam int HI_W = NS_W - DW;

    wr_state_e     state_q, state_d;
    logic [DW-1:0] stage_q;
    logic          wr_low, wr_high;

    assign wr_low  = wr_en && (addr == AW'(REG_LOW));
    assign wr_high = wr_en && (addr == AW'(REG_HIGH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            stage_q <= '0;
        end else begin
            state_q <= state_d;
            if (wr_low)
                stage_q <= wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: begin
                if (wr_low)
                    state_d = WS_LO_HELD;
            end
            WS_LO_HELD: begin
                if (wr_high)
                    state_d = WS_IDLE;
                else if (wr_low)
                    state_d = WS_LO_HELD;
            end
            default: state_d = WS_IDLE;
        endcase
    end

    always_comb begin
        commit    = 1'b0;
        commit_ns = {wdata[HI_W-1:0], stage_q};
        unique case (state_q)
            WS_IDLE:    commit = 1'b0;
            WS_LO_HELD: commit = wr_high;
            default:    commit = 1'b0;
        endcase
    end

endmodule

// File: rtl/frac_tmr_rdmux.sv
module frac_tmr_rdmux
    import frac_tmr_pkg::*;
#(
    parameter int NS_W   = 40,
    parameter int FRAC_W = 32,
    parameter int DW     = 32,
    parameter int AW     = 3
) (
    input  logic [AW-1:0]     addr,
    input  logic [FRAC_W-1:0] frac,
    input  logic [NS_W-1:0]   snap,
    input  logic [DW-1:0]     rate,
    input  logic              halt,
    output logic [DW-1:0]     rdata
);
    localparam int HI_W = NS_W - DW;

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(REG_RESID): rdata = DW'(frac);
            AW'(REG_LOW):   rdata = snap[DW-1:0];
            AW'(REG_HIGH):  rdata = {{(DW-HI_W){1'b0}}, snap[NS_W-1:DW]};
            AW'(REG_RATE):  rdata = rate;
            AW'(REG_CTRL):  rdata = {halt, {(DW-1){1'b0}}};
            default:        rdata = '0;
        endcase
    end

endmodule

// File: rtl/frac_ns_timer.sv
module frac_ns_timer
    import frac_tmr_pkg::*;
#(
    parameter int NS_W    = 40,
    parameter int FRAC_W  = 32,
    parameter int DW      = 32,
    parameter int AW      = 3,
    parameter int STEP_NS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [NS_W-1:0]   ns_q, ns_step, snap_q, commit_ns;
    logic [FRAC_W-1:0] frac_q, frac_step;
    logic [DW-1:0]     rate_q;
    logic              aux_dis;
    logic              commit;

    frac_tmr_wr_fsm #(.NS_W(NS_W), .DW(DW), .AW(AW)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .commit    (commit),
        .commit_ns (commit_ns)
    );

    frac_tmr_step #(.NS_W(NS_W), .FRAC_W(FRAC_W), .DW(DW), .STEP_NS(STEP_NS)) u_step (
        .ns_cur   (ns_q),
        .frac_cur (frac_q),
        .rate     (rate_q),
        .ns_nxt   (ns_step),
        .frac_nxt (frac_step)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns_q   <= '0;
            frac_q <= '0;
        end else if (commit) begin
            ns_q   <= commit_ns;
            frac_q <= '0;
        end else if (!aux_dis) begin
            ns_q   <= ns_step;
            frac_q <= frac_step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q  <= '0;
            aux_dis <= 1'b1;
            snap_q  <= '0;
        end else begin
            if (wr_en && addr == AW'(REG_RATE))
                rate_q <= wdata;
            if (wr_en && addr == AW'(REG_CTRL))
                aux_dis <= wdata[DW-1];
            if (rd_en && addr == AW'(REG_RESID))
                snap_q <= ns_q;
        end
    end

    frac_tmr_rdmux #(.NS_W(NS_W), .FRAC_W(FRAC_W), .DW(DW), .AW(AW)) u_rd (
        .addr  (addr),
        .frac  (frac_q),
        .snap  (snap_q),
        .rate  (rate_q),
        .halt  (aux_dis),
        .rdata (rdata)
    );

endmodule

// File: rtl/frac_tmr_chk.sv
module frac_tmr_chk
    import frac_tmr_pkg::*;
#(
    parameter int NS_W    = 40,
    parameter int FRAC_W  = 32,
    parameter int DW      = 32,
    parameter int AW      = 3,
    parameter int STEP_NS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [AW-1:0]     addr,
    input logic [DW-1:0]     rdata,
    input logic [NS_W-1:0]   ns_q,
    input logic [FRAC_W-1:0] frac_q,
    input logic [NS_W-1:0]   snap_q,
    input logic [DW-1:0]     rate_q,
    input logic              aux_dis,
    input logic              commit
);
    localparam int HI_W = NS_W - DW;

    AST_STEP_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!aux_dis && !commit && rate_q[DW-2:0] == '0) |=> (ns_q - $past(ns_q)) == NS_W'(STEP_NS)); // R3

    AST_STEP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!aux_dis && !commit && !rate_q[DW-1]) |=>
        ((ns_q - $past(ns_q)) == NS_W'(STEP_NS) || (ns_q - $past(ns_q)) == NS_W'(STEP_NS + 1))); // R4

    AST_STEP_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!aux_dis && !commit && rate_q[DW-1]) |=>
        ((ns_q - $past(ns_q)) == NS_W'(STEP_NS) || (ns_q - $past(ns_q)) == NS_W'(STEP_NS - 1))); // R5

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_dis && !commit) |=> ($stable(ns_q) && $stable(frac_q))); // R6

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == AW'(REG_RESID)) |=> $stable(snap_q)); // R7

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> frac_q == '0); // R8

    AST_HIGH_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(REG_HIGH)) |-> rdata[DW-1:HI_W] == '0); // R11

endmodule

bind frac_ns_timer frac_tmr_chk #(
    .NS_W(NS_W), .FRAC_W(FRAC_W), .DW(DW), .AW(AW), .STEP_NS(STEP_NS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .rdata   (rdata),
    .ns_q    (ns_q),
    .frac_q  (frac_q),
    .snap_q  (snap_q),
    .rate_q  (rate_q),
    .aux_dis (aux_dis),
    .commit  (commit)
);

// File: tb/tb_frac_ns_timer.sv
`timescale 1ns/1ps
module tb_frac_ns_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    frac_ns_timer dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // Reference model built from the requirements
    logic [39:0] m_ns, m_snap;
    logic [31:0] m_frac, m_rate, m_stage;
    logic        m_dis, m_held;
    logic [32:0] m_sum;
    logic [39:0] m_step;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ns <= '0; m_snap <= '0; m_frac <= '0; m_rate <= '0;
            m_stage <= '0; m_dis <= 1'b1; m_held <= 1'b0;
        end else begin
            m_sum  = {1'b0, m_frac} + {2'b0, m_rate[30:0]};
            m_step = !m_sum[32] ? 40'd8 : (m_rate[31] ? 40'd7 : 40'd9);
            if (wr_en && addr == 3'd2 && m_held) begin
                m_ns <= {wdata[7:0], m_stage};
                m_frac <= '0;
                m_held <= 1'b0;
            end else if (!m_dis) begin
                m_ns <= m_ns + m_step;
                m_frac <= m_sum[31:0];
            end
            if (wr_en && addr == 3'd1) begin
                m_stage <= wdata;
                m_held <= 1'b1;
            end
            if (wr_en && addr == 3'd3) m_rate <= wdata;
            if (wr_en && addr == 3'd4) m_dis <= wdata[31];
            if (rd_en && addr == 3'd0) m_snap <= m_ns;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_frac;
            3'd1: return m_snap[31:0];
            3'd2: return {24'd0, m_snap[39:32]};
            3'd3: return m_rate;
            3'd4: return {m_dis, 31'd0};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit rd, input bit wr, input logic [2:0] a,
                       input logic [31:0] d, output logic [31:0] got);
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = a; wdata = d;
        #2 got = rdata;
    endtask

    task automatic idle(input int n);
        logic [31:0] g;
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd7, 32'd0, g);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        logic [31:0] g;
        cyc(1'b0, 1'b1, a, d, g);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] g);
        cyc(1'b1, 1'b0, a, 32'd0, g);
    endtask

    task automatic load_ns(input logic [31:0] lo, input logic [31:0] hi);
        wr(3'd1, lo);
        wr(3'd2, hi);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] g;
        void'($urandom(32'h1588));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state, R1 map
        rd(3'd4, g); check("R2 ctrl reset", g, 32'h8000_0000);
        rd(3'd3, g); check("R2 rate reset", g, 32'd0);
        rd(3'd0, g); check("R2 residue reset", g, 32'd0);
        rd(3'd1, g); check("R2 low reset", g, 32'd0);
        rd(3'd6, g); check("R1 unmapped reads zero", g, 32'd0);

        // R3 nominal step: 10 ticks after enable -> 80
        wr(3'd4, 32'd0);
        idle(10);
        rd(3'd0, g);
        rd(3'd1, g); check("R3 ten nominal ticks", g, 32'd80);
        rd(3'd4, g); check("R6 ctrl other bits", g, 32'd0);

        // R4 positive quarter-ns rate: 8 ticks -> 66
        wr(3'd4, 32'h8000_0000);
        load_ns(32'd0, 32'd0);
        wr(3'd3, 32'h4000_0000);
        wr(3'd4, 32'd0);
        idle(8);
        rd(3'd0, g); check("R4 residue after 8 ticks", g, 32'd0);
        rd(3'd1, g); check("R4 fast rate count", g, 32'd66);

        // R5 negative quarter-ns rate: 8 ticks -> 62
        wr(3'd4, 32'h8000_0000);
        load_ns(32'd0, 32'd0);
        wr(3'd3, 32'hC000_0000);
        wr(3'd4, 32'd0);
        idle(8);
        rd(3'd0, g);
        rd(3'd1, g); check("R5 slow rate count", g, 32'd62);

        // R10 wrap at 2^40
        wr(3'd4, 32'h8000_0000);
        load_ns(32'hFFFF_FFF8, 32'h0000_00FF);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd0);
        idle(2);
        rd(3'd0, g);
        rd(3'd1, g); check("R10 wrap low", g, 32'd8);
        rd(3'd2, g); check("R10 wrap high", g, 32'd0);

        // R8 commit while halted, R11 reserved bits
        wr(3'd4, 32'h8000_0000);
        load_ns(32'h1234_5678, 32'hABCD_EF12);
        idle(4);
        rd(3'd0, g); check("R8 residue cleared", g, 32'd0);
        rd(3'd1, g); check("R8 committed low", g, 32'h1234_5678);
        rd(3'd2, g); check("R11 high reserved zero", g, 32'h0000_0012);

        // R9 lone high write and residue write ignored; R6 halt holds
        wr(3'd2, 32'h0000_0055);
        wr(3'd0, 32'hDEAD_BEEF);
        idle(5);
        rd(3'd0, g); check("R9 residue write ignored", g, 32'd0);
        rd(3'd2, g); check("R9 lone high ignored", g, 32'h0000_0012);
        rd(3'd1, g); check("R6 halted count holds", g, 32'h1234_5678);

        // R7 snapshot frozen while running
        wr(3'd4, 32'd0);
        rd(3'd0, g);
        idle(20);
        rd(3'd1, g); check("R7 snapshot frozen", g, 32'h1234_5678);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int unsigned op = $urandom_range(0, 9);
            logic [2:0] a = 3'($urandom_range(0, 5));
            logic [31:0] d = $urandom;
            if (op < 4) begin
                idle(1);
            end else if (op < 7) begin
                @(negedge clk);
                rd_en = 1'b1; wr_en = 1'b0; addr = a; wdata = '0;
                #2 check("R7 random read", rdata, exp_rd(a));
            end else begin
                if (a == 3'd4) d[31] = ($urandom_range(0, 3) == 0);
                wr(a, d);
            end
        end
        idle(1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule